// File: doc/BRIEF.md
# Filtered Programmable Event Counter Bank

This block holds a bank of general-purpose performance counters. Every clock, each counter receives an event occurrence count for that cycle, which may be larger than one. The counter also sees the privilege level and the hardware thread that produced the events. A per-counter setup word decides whether the counter takes part in that cycle and how much it adds. It can add the raw occurrence count, or add one for a cycle that meets a threshold, fails the threshold (inverted), or is the first cycle to meet it (edge).

Software sets up the bank through a flat register port. With the default four counters, addresses 0 to 3 hold the setup words, addresses 4 to 7 hold the counter values, and address 8 holds the global run bit and the sticky wrap flags. Writes land on the next rising clock edge. Reads are combinational from the current address.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset every setup word, counter value, wrap flag and the global run bit read as zero.
- R2: With threshold 0 and invert and edge both clear, a qualifying cycle adds the raw occurrence count to the counter.
- R3: A nonzero threshold T (setup bits [7:0]) adds one in each qualifying cycle where the occurrence count is at least T.
- R4: Invert (setup bit 11) adds one in qualifying cycles where the threshold condition fails. With threshold 0 the condition is "count at least 1".
- R5: Edge (setup bit 10) adds one only in a cycle where the condition holds and the condition did not hold in the previous cycle.
- R6: Edge with threshold 0 is an invalid setup. It reads back with bit 15 set and never counts.
- R7: The user enable (bit 8) allows counting at privilege levels 1, 2 and 3. The kernel enable (bit 9) allows counting at level 0. With neither enable set, the counter holds.
- R8: Without any-thread (bit 12), only events whose thread ID equals the owner field (bits [14:13]) count. With any-thread set, events from every thread count.
- R9: A counter wraps to zero past its top value and sets its sticky wrap flag at bit 8+i of the global register. Writing 1 to that bit clears the flag.
- R10: While the global run bit (bit 0 of address 8) is clear, no counter changes except by a register write.
- R11: A setup or counter write takes effect at the next rising edge. In the cycle of a counter write, the written value replaces any increment.
- R12: Each counter counts only by its own setup word and its own occurrence input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| occ_in | input | NUM_CTR*OCC_W | Per-counter occurrence count for the cycle; counter i uses slice i |
| evt_pl | input | 2 | Privilege level of the events this cycle |
| evt_tid | input | 2 | Hardware thread that produced the events this cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |

## Verification
The assertions assume that the stimulus changes only away from the rising edge. They also assume that each counter changes only by an increment of at most the largest occurrence value, or by a write. Some checks hold only in cycles without a register write, so they are written to hold off while reg_we is high. The bench meets these assumptions in three ways. It drives every input at the falling edge. It keeps occurrence values within OCC_W bits. It separates each write from the counting cycles that follow, so that every expected value can be worked out cycle by cycle.

// File: rtl/evt_ctr_pkg.sv
`timescale 1ns/1ps
package evt_ctr_pkg;

    localparam int TID_W = 2;
    localparam int THR_W = 8;

    // Setup word, LSB first: threshold[7:0], usr 8, os 9, edge 10, inv 11,
    // any 12, owner [14:13]
    typedef struct packed {
        logic [TID_W-1:0] owner;
        logic             any_thr;
        logic             inv;
        logic             edge_det;
        logic             os_en;
        logic             usr_en;
        logic [THR_W-1:0] thresh;
    } ctr_cfg_t;

    localparam int CFG_W   = $bits(ctr_cfg_t);
    localparam int BAD_BIT = 15;
    localparam int OVF_LSB = 8;

endpackage

// File: rtl/evt_ctr_qual.sv
`timescale 1ns/1ps
module evt_ctr_qual
    import evt_ctr_pkg::*;
#(
    parameter int OCC_W = 4
) (
    input  ctr_cfg_t         cfg,
    input  logic [OCC_W-1:0] occ,
    input  logic [1:0]       pl,
    input  logic [TID_W-1:0] tid,
    input  logic             prev,
    output logic             filt,
    output logic             bad,
    output logic [OCC_W-1:0] step
);

    localparam int CMP_W = (OCC_W > THR_W) ? OCC_W : THR_W;

    logic             ctx_ok;
    logic             lvl;
    logic             raw_mode;
    logic [CMP_W-1:0] occ_x;
    logic [CMP_W-1:0] thr_x;

    always_comb begin
        bad      = cfg.edge_det && (cfg.thresh == '0);
        ctx_ok   = ((pl == 2'd0) ? cfg.os_en : cfg.usr_en) &&
                   (cfg.any_thr || (tid == cfg.owner));
        occ_x    = CMP_W'(occ);
        thr_x    = (cfg.thresh == '0) ? CMP_W'(1) : CMP_W'(cfg.thresh);
        lvl      = (occ_x >= thr_x) ^ cfg.inv;
        filt     = ctx_ok && lvl && !bad;
        raw_mode = (cfg.thresh == '0) && !cfg.inv && !cfg.edge_det;
        if (bad || !ctx_ok) begin
            step = '0;
        end else if (raw_mode) begin
            step = occ;
        end else if (cfg.edge_det) begin
            step = OCC_W'(filt && !prev);
        end else begin
            step = OCC_W'(filt);
        end
    end

endmodule

// File: rtl/evt_ctr_slot.sv
`timescale 1ns/1ps
module evt_ctr_slot
    import evt_ctr_pkg::*;
#(
    parameter int CTR_W = 48,
    parameter int OCC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cfg_we,
    input  ctr_cfg_t         cfg_wdata,
    input  logic             cnt_we,
    input  logic [CTR_W-1:0] cnt_wdata,
    input  logic             ovf_clr,
    input  logic [OCC_W-1:0] occ,
    input  logic [1:0]       pl,
    input  logic [TID_W-1:0] tid,
    output ctr_cfg_t         cfg_q,
    output logic [CTR_W-1:0] cnt_q,
    output logic             ovf_q,
    output logic             bad
);

    typedef struct packed {
        ctr_cfg_t         cfg;
        logic [CTR_W-1:0] cnt;
        logic             ovf;
        logic             prev;
    } slot_t;

    slot_t            st_d, st_q;
    logic             filt;
    logic [OCC_W-1:0] step;
    logic [CTR_W:0]   sum;

    evt_ctr_qual #(.OCC_W(OCC_W)) u_qual (
        .cfg  (st_q.cfg),
        .occ  (occ),
        .pl   (pl),
        .tid  (tid),
        .prev (st_q.prev),
        .filt (filt),
        .bad  (bad),
        .step (step)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = filt;
        sum       = {1'b0, st_q.cnt} + (CTR_W+1)'(step);
        if (ovf_clr) begin
            st_d.ovf = 1'b0;
        end
        if (cnt_we) begin
            st_d.cnt = cnt_wdata;
        end else if (run) begin
            st_d.cnt = sum[CTR_W-1:0];
            if (sum[CTR_W]) begin
                st_d.ovf = 1'b1;
            end
        end
        if (cfg_we) begin
            st_d.cfg = cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q = st_q.cfg;
    assign cnt_q = st_q.cnt;
    assign ovf_q = st_q.ovf;

endmodule

// File: rtl/evt_ctr_bank.sv
`timescale 1ns/1ps
module evt_ctr_bank
    import evt_ctr_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 48,
    parameter int OCC_W   = 4,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CTR*OCC_W-1:0] occ_in,
    input  logic [1:0]               evt_pl,
    input  logic [TID_W-1:0]         evt_tid,
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata
);

    localparam int CNT_BASE = NUM_CTR;
    localparam int GLB_ADDR = 2 * NUM_CTR;

    typedef struct packed {
        logic run;
    } glb_t;

    glb_t                     glb_d, glb_q;
    logic                     glb_we;
    logic [NUM_CTR-1:0]       cfg_we, cnt_we, ovf_clr;
    logic [NUM_CTR-1:0]       ovf_vec, bad_vec, usr_vec, os_vec;
    logic [NUM_CTR*CTR_W-1:0] cnt_flat;
    ctr_cfg_t                 cfg_arr [NUM_CTR];
    logic                     run_q;

    assign glb_we = reg_we && (int'(reg_addr) == GLB_ADDR);
    assign run_q  = glb_q.run;

    always_comb begin
        glb_d = glb_q;
        if (glb_we) begin
            glb_d.run = reg_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glb_q <= '0;
        end else begin
            glb_q <= glb_d;
        end
    end

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
        assign cfg_we[i]  = reg_we && (int'(reg_addr) == i);
        assign cnt_we[i]  = reg_we && (int'(reg_addr) == CNT_BASE + i);
        assign ovf_clr[i] = glb_we && reg_wdata[OVF_LSB+i];
        assign usr_vec[i] = cfg_arr[i].usr_en;
        assign os_vec[i]  = cfg_arr[i].os_en;

        evt_ctr_slot #(.CTR_W(CTR_W), .OCC_W(OCC_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (glb_q.run),
            .cfg_we    (cfg_we[i]),
            .cfg_wdata (ctr_cfg_t'(reg_wdata[CFG_W-1:0])),
            .cnt_we    (cnt_we[i]),
            .cnt_wdata (reg_wdata[CTR_W-1:0]),
            .ovf_clr   (ovf_clr[i]),
            .occ       (occ_in[i*OCC_W +: OCC_W]),
            .pl        (evt_pl),
            .tid       (evt_tid),
            .cfg_q     (cfg_arr[i]),
            .cnt_q     (cnt_flat[i*CTR_W +: CTR_W]),
            .ovf_q     (ovf_vec[i]),
            .bad       (bad_vec[i])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (int'(reg_addr) == i) begin
                reg_rdata[CFG_W-1:0] = cfg_arr[i];
                reg_rdata[BAD_BIT]   = bad_vec[i];
            end
            if (int'(reg_addr) == CNT_BASE + i) begin
                reg_rdata[CTR_W-1:0] = cnt_flat[i*CTR_W +: CTR_W];
            end
        end
        if (int'(reg_addr) == GLB_ADDR) begin
            reg_rdata[0]                   = glb_q.run;
            reg_rdata[OVF_LSB +: NUM_CTR]  = ovf_vec;
        end
    end

endmodule

// File: rtl/evt_ctr_chk.sv
`timescale 1ns/1ps
module evt_ctr_chk #(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 48,
    parameter int OCC_W   = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_we,
    input logic                     run_q,
    input logic [NUM_CTR-1:0]       ovf_vec,
    input logic [NUM_CTR-1:0]       bad_vec,
    input logic [NUM_CTR-1:0]       usr_vec,
    input logic [NUM_CTR-1:0]       os_vec,
    input logic [NUM_CTR*CTR_W-1:0] cnt_flat
);

    localparam logic [CTR_W-1:0] MAX_STEP = CTR_W'((1 << OCC_W) - 1);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!run_q && ovf_vec == '0));

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
        // R10
        freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q && !reg_we) |=> $stable(cnt_flat[i*CTR_W +: CTR_W]));

        // R6
        invalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bad_vec[i] && !reg_we) |=> $stable(cnt_flat[i*CTR_W +: CTR_W]));

        // R7
        no_priv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!usr_vec[i] && !os_vec[i] && !reg_we)
            |=> $stable(cnt_flat[i*CTR_W +: CTR_W]));

        // R9
        wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !reg_we |=> ((cnt_flat[i*CTR_W +: CTR_W] >=
                          $past(cnt_flat[i*CTR_W +: CTR_W])) || ovf_vec[i]));

        // R2
        step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !reg_we |=> (CTR_W'(cnt_flat[i*CTR_W +: CTR_W] -
                          $past(cnt_flat[i*CTR_W +: CTR_W])) <= MAX_STEP));
    end

endmodule

bind evt_ctr_bank evt_ctr_chk #(
    .NUM_CTR (NUM_CTR),
    .CTR_W   (CTR_W),
    .OCC_W   (OCC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .run_q    (run_q),
    .ovf_vec  (ovf_vec),
    .bad_vec  (bad_vec),
    .usr_vec  (usr_vec),
    .os_vec   (os_vec),
    .cnt_flat (cnt_flat)
);

// File: tb/evt_ctr_bank_test.sv
`timescale 1ns/1ps
module evt_ctr_bank_test;

    localparam int N  = 4;
    localparam int OW = 4;
    localparam int NV = 13;

    // {setup[15:0], pl[1:0], tid[1:0], occ nibbles k3..k0, req[3:0], expect[7:0]}
    localparam logic [47:0] VEC [NV] = '{
        {16'h0100, 2'd3, 2'd0, 16'h1503, 4'd2,  8'd9 },  // R2 raw, user level
        {16'h0200, 2'd0, 2'd0, 16'h2222, 4'd7,  8'd8 },  // R7 kernel level
        {16'h0100, 2'd0, 2'd0, 16'h4444, 4'd7,  8'd0 },  // R7 user only at level 0
        {16'h0103, 2'd1, 2'd0, 16'h0732, 4'd3,  8'd2 },  // R3 threshold 3
        {16'h0903, 2'd1, 2'd0, 16'h0732, 4'd4,  8'd2 },  // R4 invert threshold 3
        {16'h0502, 2'd2, 2'd0, 16'h2043, 4'd5,  8'd2 },  // R5 edge threshold 2
        {16'h0500, 2'd2, 2'd0, 16'h0505, 4'd6,  8'd0 },  // R6 edge with threshold 0
        {16'h2100, 2'd3, 2'd2, 16'h1111, 4'd8,  8'd0 },  // R8 owner 1, thread 2
        {16'h3100, 2'd3, 2'd2, 16'h1111, 4'd8,  8'd4 },  // R8 any thread
        {16'h2100, 2'd3, 2'd1, 16'h4321, 4'd8,  8'd10},  // R8 owner matches
        {16'h0900, 2'd3, 2'd0, 16'h2010, 4'd4,  8'd2 },  // R4 invert threshold 0
        {16'h0D04, 2'd3, 2'd0, 16'h2615, 4'd5,  8'd2 },  // R5 edge of inverted
        {16'h0300, 2'd0, 2'd0, 16'h10FF, 4'd2,  8'd31}   // R2 both levels
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [N*OW-1:0]     occ_in = '0;
    logic [1:0]          evt_pl = '0;
    logic [1:0]          evt_tid = '0;
    logic                reg_we = 1'b0;
    logic [3:0]          reg_addr = '0;
    logic [63:0]         reg_wdata = '0;
    logic [63:0]         reg_rdata;
    int                  n_chk = 0;
    int                  n_fail = 0;
    logic [63:0]         rv;

    always #4 clk = ~clk;

    evt_ctr_bank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .occ_in    (occ_in),
        .evt_pl    (evt_pl),
        .evt_tid   (evt_tid),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [63:0] data);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = 4'(addr);
        reg_wdata = data;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [63:0] data);
        reg_addr = 4'(addr);
        #1;
        data = reg_rdata;
    endtask

    task automatic drive_all(input logic [OW-1:0] v);
        occ_in = {N{v}};
    endtask

    initial begin
        #1_600_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8, rv); check("R1 global", rv, 64'h0);
        rd(0, rv); check("R1 setup", rv, 64'h0);
        rd(4, rv); check("R1 count", rv, 64'h0);

        wr(8, 64'h1);

        for (int v = 0; v < NV; v++) begin
            drive_all('0);
            evt_pl  = VEC[v][31:30];
            evt_tid = VEC[v][29:28];
            wr(0, {48'h0, VEC[v][47:32]});
            wr(4, 64'h0);
            for (int k = 0; k < 4; k++) begin
                drive_all(VEC[v][12+4*k +: 4]);
                @(negedge clk);
            end
            drive_all('0);
            rd(4, rv);
            check($sformatf("R%0d vector %0d", VEC[v][11:8], v), rv, {56'h0, VEC[v][7:0]});
        end

        // R12 untouched counters stay at zero
        rd(7, rv); check("R12 counter 3", rv, 64'h0);
        rd(6, rv); check("R12 counter 2", rv, 64'h0);

        // R10 freeze while run bit clear
        evt_pl = 2'd3; evt_tid = 2'd0;
        wr(8, 64'h0);
        wr(1, 64'h0100);
        drive_all(4'd5);
        repeat (3) @(negedge clk);
        drive_all('0);
        rd(5, rv); check("R10 frozen", rv, 64'h0);
        wr(8, 64'h1);
        drive_all(4'd5);
        repeat (2) @(negedge clk);
        drive_all('0);
        rd(5, rv); check("R10 resumed", rv, 64'd10);

        // R11 write timing
        drive_all(4'd3);
        wr(5, 64'd100);
        rd(5, rv); check("R11 load wins", rv, 64'd100);
        @(negedge clk);
        rd(5, rv); check("R11 count after load", rv, 64'd103);
        wr(1, 64'h0);
        rd(5, rv); check("R11 old setup at write edge", rv, 64'd109);
        @(negedge clk);
        rd(5, rv); check("R11 new setup active", rv, 64'd109);
        drive_all('0);

        // R9 wrap and sticky flag
        wr(2, 64'h0100);
        wr(6, 64'h0000_FFFF_FFFF_FFFE);
        drive_all(4'd3);
        @(negedge clk);
        drive_all('0);
        rd(6, rv); check("R9 wrapped value", rv, 64'd1);
        rd(8, rv); check("R9 flag set", rv, 64'h401);
        @(negedge clk);
        rd(8, rv); check("R9 flag sticky", rv, 64'h401);
        wr(8, 64'h401);
        rd(8, rv); check("R9 flag cleared", rv, 64'h1);

        // R6 invalid setup read back and no counting
        wr(3, 64'h0500);
        rd(3, rv); check("R6 invalid flag", rv, 64'h8500);
        drive_all(4'd7);
        repeat (2) @(negedge clk);
        drive_all('0);
        rd(7, rv); check("R6 no count", rv, 64'h0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule